// File: doc/BRIEF.md
# Split-Transaction Bus Arbiter

This block is the central arbiter of a shared processor bus whose address phase and data phase are granted separately. Masters raise a request line. The arbiter picks one of them in rotating order and gives it the address bus. It acknowledges the address tenure that the master then starts, and records the tenure in a queue of pending data tenures. The data bus is granted from the head of that queue. New address tenures can therefore be acknowledged while older data tenures are still waiting or moving beats. The result is a pipelined bus whose depth is set by a configuration input.

Inside the block, the pending-tenure queue is a valid/ready stream. The address side pushes one entry per acknowledged tenure. The data side pops the head entry only while the data bus is idle, so an unready head is held and never lost. The address side never stalls on a full queue, because it grants only when the queue has room for the tenure it is about to acknowledge. The bus pins are plain level signals, all active high, with no back-pressure at the edge. A master drops its request once it has started its transfer, or keeps it high to ask again.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every address grant, every data grant and the address acknowledge are low, and the pending queue is empty.
- R2: At most one address grant is high at a time. It goes only to a master whose request is high, and it stays unchanged until that master pulses transfer-start.
- R3: Competing requesters are served in rotating order: after master k is granted, the search for the next grant starts at master k+1 and wraps around.
- R4: Address acknowledge is high for exactly the one cycle after a transfer-start made under an address grant, and that cycle is the address-busy cycle. No address grant is visible in that cycle, and a transfer-start without a grant has no effect.
- R5: Each data grant is a one-hot vector naming the master that owns the oldest acknowledged tenure still without a data grant. Data grants are issued strictly in acknowledge order.
- R6: The data bus stays busy from its grant until the last transfer-acknowledge beat. A tenure flagged as burst (burst input high with transfer-start) takes four beats, and one that is not takes one beat. No new data grant appears while beats are outstanding.
- R7: With the pipeline-depth input d between 1 and 6, a new address grant is issued only while fewer than d acknowledged tenures are waiting for a data grant. Values above 6 act as 6.
- R8: With depth input 0, no address grant is issued until the queue is empty and the previous data tenure has completed.
- R9: A data grant lasts exactly one cycle. Transfer-acknowledge while the data bus is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | N_MASTERS | Per-master request lines |
| pipe_depth | input | CFG_W | Maximum number of pending tenures (0 to 6, larger values clamp to 6) |
| xfer_start | input | 1 | Transfer-start from the address-bus owner |
| xfer_burst | input | 1 | Burst flag, sampled with xfer_start |
| xfer_ack | input | 1 | Transfer-acknowledge, one per data beat |
| addr_gnt | output | N_MASTERS | One-hot address-bus grant |
| data_gnt | output | N_MASTERS | One-hot, one-cycle data-bus grant |
| addr_ack | output | 1 | Address acknowledge, ends an address tenure |

## Verification
The bench builds the block with its default parameters: four masters, a queue of six entries and four beats per burst. A three-bit depth input therefore reaches every legal depth and the clamped value 7. Holding transfer-acknowledge off with all four masters requesting fills the queue to exactly the configured depth, including all six entries. The bench then counts the address grants issued. Four masters also make the rotating order wrap several times, and mixed single and burst tenures show the beat counting on back-to-back data grants.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic [1:0] {
    A_IDLE  = 2'd0,
    A_GRANT = 2'd1,
    A_ACK   = 2'd2
  } addr_st_e;

  typedef enum logic {
    D_IDLE = 1'b0,
    D_XFER = 1'b1
  } data_st_e;
endpackage

// File: rtl/arb_rr_pick.sv
`timescale 1ns/1ps
module arb_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last_idx,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  // Search starts one past the previous winner and wraps.
  always_comb begin
    int c;
    any = 1'b0;
    win = '0;
    c   = 0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last_idx) + k) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        win = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/arb_tenure_fifo.sv
`timescale 1ns/1ps
module arb_tenure_fifo #(
  parameter int DEPTH = 6,
  parameter int W     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign count     = cnt;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/arb_data_ctrl.sv
`timescale 1ns/1ps
module arb_data_ctrl
  import arb_pkg::*;
#(
  parameter int N           = 4,
  parameter int IDX_W       = 2,
  parameter int BURST_BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  output logic             head_ready,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             head_burst,
  input  logic             beat_ack,
  output logic [N-1:0]     dgnt,
  output logic             busy
);
  localparam int BW = $clog2(BURST_BEATS + 1);

  data_st_e      st;
  logic [BW-1:0] beats;
  logic [N-1:0]  dgnt_q;

  assign head_ready = (st == D_IDLE);
  assign busy       = (st == D_XFER);
  assign dgnt       = dgnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= D_IDLE;
      beats  <= '0;
      dgnt_q <= '0;
    end else begin
      dgnt_q <= '0;
      case (st)
        D_IDLE: if (head_valid) begin
          dgnt_q <= N'(1) << head_idx;
          beats  <= head_burst ? BW'(BURST_BEATS) : BW'(1);
          st     <= D_XFER;
        end
        D_XFER: if (beat_ack) begin
          beats <= beats - 1'b1;
          if (beats == BW'(1)) st <= D_IDLE;
        end
        default: st <= D_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/split_bus_arbiter.sv
`timescale 1ns/1ps
module split_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS   = 4,
  parameter int MAX_PIPE    = 6,
  parameter int BURST_BEATS = 4,
  parameter int CFG_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] bus_req,
  input  logic [CFG_W-1:0]     pipe_depth,
  input  logic                 xfer_start,
  input  logic                 xfer_burst,
  input  logic                 xfer_ack,
  output logic [N_MASTERS-1:0] addr_gnt,
  output logic [N_MASTERS-1:0] data_gnt,
  output logic                 addr_ack
);
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int CNT_W = $clog2(MAX_PIPE + 1);
  localparam int ENT_W = IDX_W + 1;

  addr_st_e               a_st;
  logic [IDX_W-1:0]       owner, last_idx, pick_idx, head_idx;
  logic                   pick_any, burst_q, head_burst;
  logic [N_MASTERS-1:0]   agnt_q;
  logic [CNT_W-1:0]       pend_cnt;
  logic [CFG_W-1:0]       lim;
  logic                   room, data_busy;
  logic                   q_push_valid, q_push_ready, q_head_valid, q_head_ready;
  logic [ENT_W-1:0]       q_head;

  arb_rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req(bus_req), .last_idx(last_idx), .any(pick_any), .win(pick_idx)
  );

  // Depth limit: clamp the setting, then compare against waiting tenures.
  always_comb begin
    lim = (int'(pipe_depth) > MAX_PIPE) ? CFG_W'(MAX_PIPE) : pipe_depth;
    if (lim == '0) room = (pend_cnt == '0) && !data_busy;
    else           room = int'(pend_cnt) < int'(lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_st     <= A_IDLE;
      agnt_q   <= '0;
      owner    <= '0;
      last_idx <= IDX_W'(N_MASTERS - 1);
      burst_q  <= 1'b0;
    end else begin
      case (a_st)
        A_IDLE: if (pick_any && room) begin
          agnt_q   <= N_MASTERS'(1) << pick_idx;
          owner    <= pick_idx;
          last_idx <= pick_idx;
          a_st     <= A_GRANT;
        end
        A_GRANT: if (xfer_start) begin
          agnt_q  <= '0;
          burst_q <= xfer_burst;
          a_st    <= A_ACK;
        end
        A_ACK:   a_st <= A_IDLE;
        default: a_st <= A_IDLE;
      endcase
    end
  end

  assign addr_gnt     = agnt_q;
  assign addr_ack     = (a_st == A_ACK);
  assign q_push_valid = (a_st == A_ACK);

  arb_tenure_fifo #(.DEPTH(MAX_PIPE), .W(ENT_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(q_push_valid), .in_ready(q_push_ready), .in_data({burst_q, owner}),
    .out_valid(q_head_valid), .out_ready(q_head_ready), .out_data(q_head),
    .count(pend_cnt)
  );

  assign head_idx   = q_head[IDX_W-1:0];
  assign head_burst = q_head[ENT_W-1];

  arb_data_ctrl #(.N(N_MASTERS), .IDX_W(IDX_W), .BURST_BEATS(BURST_BEATS)) u_data (
    .clk(clk), .rst_n(rst_n),
    .head_valid(q_head_valid), .head_ready(q_head_ready),
    .head_idx(head_idx), .head_burst(head_burst),
    .beat_ack(xfer_ack), .dgnt(data_gnt), .busy(data_busy)
  );
endmodule

// File: rtl/arb_checker.sv
`timescale 1ns/1ps
module arb_checker #(
  parameter int N_MASTERS = 4,
  parameter int MAX_PIPE  = 6,
  parameter int CFG_W     = 3,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] addr_gnt,
  input logic [N_MASTERS-1:0] data_gnt,
  input logic                 addr_ack,
  input logic                 xfer_start,
  input logic [CFG_W-1:0]     pipe_depth,
  input logic [CNT_W-1:0]     pend_cnt,
  input logic                 data_busy,
  input logic                 q_push_valid,
  input logic                 q_push_ready
);
  int eff_lim;
  assign eff_lim = (int'(pipe_depth) > MAX_PIPE) ? MAX_PIPE : int'(pipe_depth);

  p_agnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_gnt));

  p_agnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_gnt && !xfer_start) |=> $stable(addr_gnt));

  p_ack_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> $past(xfer_start && |addr_gnt));

  p_no_gnt_while_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> !(|addr_gnt));

  p_dgnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_gnt));

  p_dgnt_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |data_gnt |-> !$past(data_busy));

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|addr_gnt) && $past(eff_lim) != 0) |-> $past(int'(pend_cnt) < eff_lim));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_push_valid |-> q_push_ready);

  p_depth_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|addr_gnt) && $past(eff_lim) == 0) |-> $past(pend_cnt == '0 && !data_busy));

  p_dgnt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |data_gnt |=> !(|data_gnt));
endmodule

bind split_bus_arbiter arb_checker #(
  .N_MASTERS(N_MASTERS), .MAX_PIPE(MAX_PIPE), .CFG_W(CFG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_gnt(addr_gnt), .data_gnt(data_gnt),
  .addr_ack(addr_ack), .xfer_start(xfer_start), .pipe_depth(pipe_depth),
  .pend_cnt(pend_cnt), .data_busy(data_busy),
  .q_push_valid(q_push_valid), .q_push_ready(q_push_ready)
);

// File: tb/test_split_bus_arbiter.sv
`timescale 1ns/1ps
module test_split_bus_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [2:0]   cfg = 3'd6;
  logic         ts = 1'b0, tb_burst = 1'b0, ta = 1'b0;
  logic [N-1:0] agnt, dgnt;
  logic         aack;

  int checks = 0, errors = 0;

  typedef struct { int m; bit b; } ten_t;
  ten_t exp_q[$];

  // control variables, written by the sequence, read by the bus model
  bit auto_req = 0, hold_ta = 0, stray_ta = 0, stray_ts = 0;
  int bmode = 0;
  int last_w = N - 1;
  int beats_left = 0;
  int grants = 0;
  bit fired_prev = 0;

  always #10 clk = ~clk;

  split_bus_arbiter i_split_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .pipe_depth(cfg),
    .xfer_start(ts), .xfer_burst(tb_burst), .xfer_ack(ta),
    .addr_gnt(agnt), .data_gnt(dgnt), .addr_ack(aack)
  );

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rr_exp(input logic [N-1:0] r, input int last);
    for (int k = 1; k <= N; k++) begin
      if (r[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  function automatic int lim_of(input logic [2:0] c);
    return (int'(c) > 6) ? 6 : int'(c);
  endfunction

  // Bus model: masters, data responder and scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n) begin
      bit fire;
      int w;
      fire = 0;
      ck(aack == fired_prev, "R4 aack timing", int'(aack), int'(fired_prev));
      if (|agnt) begin
        w = $clog2(agnt);
        ck($onehot(agnt), "R2 onehot grant", int'(agnt), 1 << w);
        ck(req[w], "R2 grant to requester", int'(req), 1 << w);
        ck(w == rr_exp(req, last_w), "R3 rotating order", w, rr_exp(req, last_w));
        if (lim_of(cfg) > 0)
          ck(exp_q.size() < lim_of(cfg), "R7 depth bound", exp_q.size(), lim_of(cfg));
        else
          ck(exp_q.size() == 0 && beats_left == 0, "R8 depth zero",
             exp_q.size() + beats_left, 0);
        last_w = w;
        grants++;
        fire = 1;
        tb_burst = (bmode == 2) || (bmode == 1 && w[0]);
        exp_q.push_back('{m: w, b: tb_burst});
        if (!auto_req) req[w] = 1'b0;
      end
      if (|dgnt) begin
        ck(beats_left == 0, "R6 grant during beats", beats_left, 0);
        if (exp_q.size() == 0) begin
          ck(0, "R5 unexpected data grant", int'(dgnt), 0);
        end else begin
          ten_t e;
          e = exp_q.pop_front();
          ck(dgnt == N'(1 << e.m), "R5 data grant order", int'(dgnt), 1 << e.m);
          beats_left = e.b ? 4 : 1;
        end
      end
      ta = stray_ta;
      if (beats_left > 0 && !hold_ta) begin
        ta = 1'b1;
        beats_left--;
      end
      ts = fire | stray_ts;
      fired_prev = fire;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic drain();
    int t;
    req = '0;
    auto_req = 0;
    hold_ta = 0;
    t = 0;
    while ((exp_q.size() != 0 || beats_left != 0 || |agnt) && t < 2000) begin
      step(1);
      t++;
    end
    ck(t < 2000, "R5 drain complete", exp_q.size(), 0);
    step(4);
  endtask

  task automatic depth_run(input logic [2:0] c, input int exp_g, input string tag);
    cfg = c;
    hold_ta = 1;
    grants = 0;
    auto_req = 1;
    req = '1;
    step(80);
    ck(grants == exp_g, tag, grants, exp_g);
    ck(agnt == '0, tag, int'(agnt), 0);
    drain();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(5);
    ck(agnt == '0 && dgnt == '0 && aack == 1'b0, "R1 reset outputs",
       int'({agnt, dgnt, aack}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ck(agnt == '0 && dgnt == '0 && aack == 1'b0, "R1 first cycle after reset",
       int'({agnt, dgnt, aack}), 0);
    step(1);

    // R9 / R4: stray acknowledge and start while idle change nothing
    stray_ta = 1;
    stray_ts = 1;
    step(6);
    stray_ta = 0;
    stray_ts = 0;
    ck(agnt == '0 && dgnt == '0 && aack == 1'b0, "R9 stray inputs ignored",
       int'({agnt, dgnt, aack}), 0);
    step(2);

    // single burst tenure, data held, proves idle beats were not counted (R9, R6)
    bmode = 2;
    hold_ta = 1;
    req = 4'b0100;
    step(12);
    ck(beats_left == 4 && exp_q.size() == 0, "R6 burst beats pending", beats_left, 4);
    drain();

    // all four at once, mixed lengths: rotating order and in-order data (R3, R5, R6)
    bmode = 1;
    req = '1;
    step(40);
    drain();

    // long pipelined run at full depth
    cfg = 3'd6;
    auto_req = 1;
    req = 4'b1011;
    step(300);
    drain();

    bmode = 0;
    depth_run(3'd2, 3, "R7 depth two grants");
    depth_run(3'd7, 7, "R7 clamped depth grants");
    depth_run(3'd1, 2, "R7 depth one grants");
    depth_run(3'd0, 1, "R8 depth zero grants");

    ck(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule